// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block watches bus cycles opened by the local processor. It counts system clocks from the opening of a cycle until a data acknowledge or an autovector acknowledge closes it. If the selected limit comes first, it raises a one-clock bus error pulse. A 2-bit select picks one of four limits. An enable bit decides whether cycles that leave for the external bus are timed at all. Cycles that stay internal are always timed.

Two cycle types get special handling:

- **8-bit port word transfers.** These are flagged at cycle start. They need two acknowledges to close, and the count runs unbroken across both byte halves.
- **Interrupt-acknowledge cycles.** These are also flagged at cycle start. They must see interrupt arbitration within a short fixed window. If they do not, a bus error is raised. This spurious-interrupt check cannot be switched off.

All cycle attributes, the timeout select and the enable are captured on the clock where the cycle opens. A start is accepted only while no cycle is open.

Top module: `bus_timeout_mon`

## Requirements
- R1: The select `tmo_sel_i` maps 2'b00 to 64, 2'b01 to 32, 2'b10 to 16 and 2'b11 to 8 clocks. Call that number N. A timed cycle that opens on edge k and sees no acknowledge raises `berr_o` after edge k+N.
- R2: A `data_ack_i` or `avec_ack_i` sampled on any edge k+1 to k+N closes the cycle with no bus error. An acknowledge on edge k+N, the same edge as the terminal count, wins.
- R3: A start with `cyc_local_i`=0 opens no cycle. No bus error follows, and the next local start is accepted normally.
- R4: A cycle with `cyc_ext_i`=1 is timed only if `mon_en_i`=1 at its start; otherwise it never times out. A cycle with `cyc_ext_i`=0 is timed whatever `mon_en_i` is.
- R5: With `port8_i`=1 at start, the first acknowledge does not close the cycle or clear the count. The second acknowledge closes it. The timeout is measured from the start across both halves.
- R6: With `iack_i`=1 at start and ARB_WIN=4, missing `irq_arb_i` on edges k+1 to k+4 (and no closing acknowledge) raises `berr_o` after edge k+4. An `irq_arb_i` on edge k+4 wins, and after arbitration the normal timeout applies.
- R7: The spurious-interrupt check of R6 acts regardless of `mon_en_i` and `cyc_ext_i`.
- R8: `berr_o` is a pulse of exactly one clock that closes the cycle. A start on the edge that raises it is ignored; a start on the next edge is accepted.
- R9: `tmo_sel_i` is sampled only at cycle start. Changing it while a cycle is open does not alter that cycle's limit.
- R10: A start while a cycle is open is ignored and does not restart the count.
- R11: While and right after `rst_ni` is low, `berr_o` is 0 and no cycle is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_start_i | input | 1 | Bus cycle opens on this clock |
| cyc_local_i | input | 1 | Cycle initiated by the local processor |
| cyc_ext_i | input | 1 | Cycle goes to the external bus |
| port8_i | input | 1 | Word transfer to an 8-bit port (two acknowledges) |
| iack_i | input | 1 | Interrupt-acknowledge cycle |
| tmo_sel_i | input | 2 | Timeout select, see R1 |
| mon_en_i | input | 1 | Enable timing of external cycles |
| data_ack_i | input | 1 | Data transfer acknowledge |
| avec_ack_i | input | 1 | Autovector acknowledge |
| irq_arb_i | input | 1 | Interrupt arbitration occurred |
| berr_o | output | 1 | Bus error pulse |

## Verification
Each fault in the latched state shows up as a wrong edge for the first bus error pulse, or as a missing or extra pulse. Examples:

- A stale or wrongly decoded limit moves the pulse away from edge k+N.
- A lost half-transfer flag ends 8-bit word transfers early.
- A dropped arbitration flag fires the spurious error four clocks into an interrupt-acknowledge cycle.

Every such fault shows within at most 64 clocks of the cycle start. The bench therefore records the exact edge of each pulse and its width.

// File: rtl/bmon_pkg.sv
package bmon_pkg;
  typedef struct packed {
    logic timed;     // timeout armed for this cycle
    logic iack;      // interrupt-acknowledge cycle
    logic two_acks;  // 8-bit port word transfer
  } cyc_attr_t;
endpackage

// File: rtl/bmon_limit_dec.sv
module bmon_limit_dec #(
  parameter int BASE_CLKS = 8,
  parameter int SEL_W     = 2,
  parameter int CNT_W     = 7
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] lim_o
);
  localparam int NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] lut [NSEL];

  // inverse coding: all-zero select gives the longest period
  for (genvar g = 0; g < NSEL; g++) begin : g_lut
    assign lut[g] = CNT_W'(BASE_CLKS << (NSEL - 1 - g));
  end

  assign lim_o = lut[sel_i];
endmodule

// File: rtl/bmon_counter.sv
module bmon_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (clr_i)                      cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + CNT_W'(1);  // saturate on untimed cycles
  end
endmodule

// File: rtl/bmon_ctrl.sv
module bmon_ctrl
  import bmon_pkg::*;
#(
  parameter int CNT_W   = 7,
  parameter int ARB_WIN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             local_i,
  input  cyc_attr_t        attr_i,
  input  logic             ack_i,
  input  logic             arb_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clr_o,
  output logic             inc_o,
  output logic             active_o,
  output logic             armed_o,
  output logic             iack_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             berr_o
);
  localparam logic [CNT_W-1:0] ARB_LAST = CNT_W'(ARB_WIN - 1);

  logic      active_q, half_q, arb_q;
  cyc_attr_t attr_q;
  logic [CNT_W-1:0] lim_q;
  logic      open_c, ack_done, tmo_hit, spur_hit, close_c;

  assign open_c   = !active_q && start_i && local_i;
  assign ack_done = active_q && ack_i && (!attr_q.two_acks || half_q);
  // acknowledge on the terminal edge takes priority over either error
  assign tmo_hit  = active_q && attr_q.timed && (cnt_i == lim_q - CNT_W'(1)) && !ack_done;
  assign spur_hit = active_q && attr_q.iack && !arb_q && !arb_i &&
                    (cnt_i == ARB_LAST) && !ack_done;
  assign close_c  = ack_done || tmo_hit || spur_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      arb_q    <= 1'b0;
      attr_q   <= '0;
      lim_q    <= '0;
      berr_o   <= 1'b0;
    end else begin
      berr_o <= tmo_hit || spur_hit;
      if (open_c) begin
        active_q <= 1'b1;
        half_q   <= 1'b0;
        arb_q    <= 1'b0;
        attr_q   <= attr_i;
        lim_q    <= lim_i;
      end else if (active_q) begin
        if (ack_i) half_q <= 1'b1;
        if (arb_i) arb_q  <= 1'b1;
        if (close_c) active_q <= 1'b0;
      end
    end
  end

  assign clr_o    = open_c;
  assign inc_o    = active_q && !close_c;
  assign active_o = active_q;
  assign armed_o  = attr_q.timed;
  assign iack_o   = attr_q.iack;
  assign lim_o    = lim_q;
endmodule

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon
  import bmon_pkg::*;
#(
  parameter int BASE_CLKS = 8,
  parameter int SEL_W     = 2,
  parameter int ARB_WIN   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_start_i,
  input  logic             cyc_local_i,
  input  logic             cyc_ext_i,
  input  logic             port8_i,
  input  logic             iack_i,
  input  logic [SEL_W-1:0] tmo_sel_i,
  input  logic             mon_en_i,
  input  logic             data_ack_i,
  input  logic             avec_ack_i,
  input  logic             irq_arb_i,
  output logic             berr_o
);
  localparam int NSEL    = 1 << SEL_W;
  localparam int MAX_LIM = BASE_CLKS << (NSEL - 1);
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  cyc_attr_t        attr;
  logic [CNT_W-1:0] lim_sel, lim_q, cnt;
  logic             clr, inc, active, armed, iack_q;

  assign attr.timed    = !cyc_ext_i || mon_en_i;
  assign attr.iack     = iack_i;
  assign attr.two_acks = port8_i;

  bmon_limit_dec #(.BASE_CLKS(BASE_CLKS), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_dec (
    .sel_i (tmo_sel_i),
    .lim_o (lim_sel)
  );

  bmon_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (inc),
    .cnt_o  (cnt)
  );

  bmon_ctrl #(.CNT_W(CNT_W), .ARB_WIN(ARB_WIN)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (cyc_start_i),
    .local_i  (cyc_local_i),
    .attr_i   (attr),
    .ack_i    (data_ack_i || avec_ack_i),
    .arb_i    (irq_arb_i),
    .lim_i    (lim_sel),
    .cnt_i    (cnt),
    .clr_o    (clr),
    .inc_o    (inc),
    .active_o (active),
    .armed_o  (armed),
    .iack_o   (iack_q),
    .lim_o    (lim_q),
    .berr_o   (berr_o)
  );
endmodule

// File: rtl/bmon_chk.sv
module bmon_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_start_i,
  input logic             cyc_local_i,
  input logic             berr_o,
  input logic             active,
  input logic             armed,
  input logic             iack_q,
  input logic [CNT_W-1:0] lim_q,
  input logic [CNT_W-1:0] cnt
);
  assert_cnt_below_lim_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && armed) |-> (cnt < lim_q));

  assert_foreign_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && cyc_start_i && !cyc_local_i) |=> !active);

  assert_untimed_only_spur_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (berr_o && !$past(armed)) |-> $past(iack_q));

  assert_one_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |=> !berr_o);

  assert_berr_from_open_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> $past(active));

  assert_sel_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && $past(active)) |-> $stable(lim_q));

  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && cyc_start_i) |=> (cnt != '0 || !active));
endmodule

bind bus_timeout_mon bmon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cyc_start_i (cyc_start_i),
  .cyc_local_i (cyc_local_i),
  .berr_o      (berr_o),
  .active      (active),
  .armed       (armed),
  .iack_q      (iack_q),
  .lim_q       (lim_q),
  .cnt         (cnt)
);

// File: tb/tb_bus_timeout_mon.sv
module tb_bus_timeout_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, loc = 1'b1, ext = 1'b0, p8 = 1'b0, iack = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       en = 1'b1, ack = 1'b0, avec = 1'b0, arb = 1'b0;
  logic       berr;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bus_timeout_mon dut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_start_i(start), .cyc_local_i(loc),
    .cyc_ext_i(ext), .port8_i(p8), .iack_i(iack), .tmo_sel_i(sel),
    .mon_en_i(en), .data_ack_i(ack), .avec_ack_i(avec), .irq_arb_i(arb),
    .berr_o(berr)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic ext, en, p8, iack, use_avec;
    logic [7:0] ack1, ack2, arb, exp_edge;
  } vec_t;

  // exp_edge: edge after start that shows berr, 0 = none
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'b00,1'b0,1'b1,1'b0,1'b0,1'b0,8'd0, 8'd0, 8'd0,8'd64}, // R1
    '{2'b01,1'b1,1'b1,1'b0,1'b0,1'b0,8'd0, 8'd0, 8'd0,8'd32}, // R1
    '{2'b10,1'b0,1'b1,1'b0,1'b0,1'b0,8'd0, 8'd0, 8'd0,8'd16}, // R1
    '{2'b11,1'b0,1'b1,1'b0,1'b0,1'b0,8'd0, 8'd0, 8'd0,8'd8},  // R1
    '{2'b11,1'b0,1'b1,1'b0,1'b0,1'b0,8'd8, 8'd0, 8'd0,8'd0},  // R2 ack on terminal edge
    '{2'b11,1'b1,1'b1,1'b0,1'b0,1'b1,8'd7, 8'd0, 8'd0,8'd0},  // R2 autovector
    '{2'b10,1'b1,1'b0,1'b0,1'b0,1'b0,8'd70,8'd0, 8'd0,8'd0},  // R4 external untimed
    '{2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,8'd0, 8'd0, 8'd0,8'd8},  // R4 internal timed
    '{2'b10,1'b0,1'b1,1'b1,1'b0,1'b0,8'd5, 8'd0, 8'd0,8'd16}, // R5 one half only
    '{2'b10,1'b0,1'b1,1'b1,1'b0,1'b0,8'd5, 8'd12,8'd0,8'd0},  // R5 both halves
    '{2'b11,1'b0,1'b1,1'b1,1'b0,1'b0,8'd3, 8'd8, 8'd0,8'd0},  // R5 second ack on terminal
    '{2'b00,1'b0,1'b1,1'b0,1'b1,1'b0,8'd0, 8'd0, 8'd0,8'd4},  // R6 spurious
    '{2'b11,1'b0,1'b1,1'b0,1'b1,1'b0,8'd0, 8'd0, 8'd4,8'd8},  // R6 arb on last edge
    '{2'b11,1'b1,1'b0,1'b0,1'b1,1'b0,8'd0, 8'd0, 8'd0,8'd4},  // R7 spurious, untimed
    '{2'b11,1'b1,1'b0,1'b0,1'b1,1'b0,8'd70,8'd0, 8'd2,8'd0}   // R7 arb seen, untimed
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // step edges 1..n, record first berr edge and number of high samples
  task automatic watch(input int n, input int a1, input int a2, input int ar, input bit av,
                       output int first, output int highs);
    first = 0; highs = 0;
    for (int e = 1; e <= n; e++) begin
      ack  = !av && (e == a1 || e == a2);
      avec =  av && (e == a1 || e == a2);
      arb  = (e == ar);
      tick();
      ack = 1'b0; avec = 1'b0; arb = 1'b0;
      if (berr) begin
        if (first == 0) first = e;
        highs++;
      end
    end
  endtask

  task automatic open_cycle(input logic [1:0] s, input logic x, input logic m,
                            input logic b8, input logic ia);
    sel = s; ext = x; en = m; p8 = b8; iack = ia; start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  initial begin
    int first, highs;
    #1;
    check(berr === 1'b0, "R11 reset", berr, 0);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(berr === 1'b0, "R11 after reset", berr, 0);

    for (int i = 0; i < NV; i++) begin
      open_cycle(VECS[i].sel, VECS[i].ext, VECS[i].en, VECS[i].p8, VECS[i].iack);
      watch(70, VECS[i].ack1, VECS[i].ack2, VECS[i].arb, VECS[i].use_avec, first, highs);
      check(first == int'(VECS[i].exp_edge), $sformatf("vec %0d berr edge", i),
            first, VECS[i].exp_edge);
      check(highs == (VECS[i].exp_edge != 0 ? 1 : 0), $sformatf("vec %0d R8 pulse width", i),
            highs, VECS[i].exp_edge != 0 ? 1 : 0);
      tick();
    end

    // R3: foreign master start ignored, then local start accepted
    loc = 1'b0;
    open_cycle(2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
    loc = 1'b1;
    watch(20, 0, 0, 0, 1'b0, first, highs);
    check(highs == 0, "R3 foreign cycle no berr", highs, 0);
    open_cycle(2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
    watch(12, 0, 0, 0, 1'b0, first, highs);
    check(first == 8, "R3 next local start", first, 8);

    // R9: select changed right after start
    open_cycle(2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
    sel = 2'b00;
    watch(12, 0, 0, 0, 1'b0, first, highs);
    check(first == 8, "R9 select held", first, 8);
    open_cycle(2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
    sel = 2'b11;
    watch(70, 0, 0, 0, 1'b0, first, highs);
    check(first == 64, "R9 select held long", first, 64);

    // R10 + R8: start held high; only edges 0 and 9 open cycles
    sel = 2'b11; ext = 1'b0; en = 1'b1; p8 = 1'b0; iack = 1'b0; start = 1'b1;
    tick();
    first = 0; highs = 0;
    for (int e = 1; e <= 20; e++) begin
      tick();
      if (berr) begin
        highs++;
        if (e == 8)  check(1'b1, "R10 first berr at 8", e, 8);
        else if (e == 17) check(1'b1, "R8 restart berr at 17", e, 17);
        else check(1'b0, "R8/R10 unexpected berr edge", e, 0);
      end
    end
    start = 1'b0;
    check(highs == 2, "R8 R10 berr count", highs, 2);
    repeat (20) tick();
    check(berr === 1'b0, "R8 idle after cycles", berr, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule